// File: doc/BRIEF.md
# AES-128 Equivalent Inverse Cipher Engine

This block decrypts one 128-bit block with AES-128. The round order is arranged so that each middle round has the same shape as an encryption round: byte substitution, row shift, column mix, then key XOR. To make this work, rounds 9 to 1 use round keys that have already been passed through the inverse column mix. Raw keys are used only for round 10 and round 0.

A start pulse captures the ciphertext. The engine then waits until the external key schedule reports ready. It reads each round key through an index output and a 128-bit data input; the key store answers combinationally in the same cycle. The initial key XOR takes one cycle. Each middle round takes four cycles and the final round takes three. The result goes into a plaintext register, and a done flag is raised at the same time.

Top module: `aes_eic_dec`

## Requirements
- R1: While reset is low, `busy`, `done` and `plaintext` are all zero.
- R2: A start pulse while idle captures `ciphertext`. Changes on `ciphertext` after that edge do not affect the result.
- R3: After a start, no round work happens while `key_ready` is low. `done` stays low and the result does not depend on how long the wait lasts.
- R4: While waiting and during the first operation, `key_idx` is 10. The ciphertext is XORed with the raw round-10 key read at that index.
- R5: Rounds 9 down to 1 each apply inverse substitution, inverse row shift and inverse column mix, then XOR the premixed key at index r. Each of these rounds takes exactly four cycles, and `key_idx` drops by one at the end of each.
- R6: The final round reads the raw key at index 0. It applies inverse substitution and inverse row shift, skips the column mix, and XORs the key to form the plaintext. `plaintext` changes only in the cycle `done` rises.
- R7: If `key_ready` is high at the first edge after the accepting edge, `done` and `plaintext` appear exactly 40 edges after the accepting edge. In general they appear 40 edges after the accepting edge plus one edge per cycle of waiting.
- R8: `done` stays high until the next accepted start, which clears it. `done` and `busy` are never high together.
- R9: A start pulse while `busy` is high is ignored.
- R10: Byte k of the state (k = 4*column + row) occupies bits [127-8k -: 8] of the 128-bit words, and the block reproduces the standard AES-128 known-answer decryption.
- R11: `key_idx` never exceeds 10. During round r it equals r, so it follows 9..1 and then 0 in lockstep with the round schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, honoured only while idle |
| key_ready | input | 1 | Key schedule complete; gates the first operation |
| ciphertext | input | 128 | Block to decrypt, captured on start |
| key_idx | output | 4 | Round key index requested (10..0) |
| key_data | input | 128 | Round key at `key_idx`, same cycle |
| plaintext | output | 128 | Decrypted block register |
| done | output | 1 | Result valid, held until the next start |
| busy | output | 1 | Start accepted and result not yet written |

## Verification
The bench goes after four corner cases:
- **Timing skew:** Outputs are compared cycle by cycle against a timing model. A round schedule off by one cycle shows up as `done` rising one edge early or late.
- **Key indexing:** Keys are served only through `key_idx`. An engine that used the raw key in a middle round, or mixed the final round, would produce a wrong plaintext against both the known-answer block and random blocks.
- **Start handling:** A stalled start, a ciphertext change after capture and a start pulse during a run all leave the expected result unchanged. An engine that recaptured the input or restarted would show a different plaintext or a longer latency.
- **Done handling:** A restart from the done state is checked to clear `done` on the accepting edge.

// File: rtl/aes_eic_dec.sv
module aes_eic_dec (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         key_ready,
  input  logic [127:0] ciphertext,
  output logic [3:0]   key_idx,
  input  logic [127:0] key_data,
  output logic [127:0] plaintext,
  output logic         done,
  output logic         busy
);

  localparam logic [3:0] LAST_RND = 4'd10;

  logic         run;
  logic [1:0]   phase;
  logic [3:0]   rc;
  logic [127:0] ct_r, state, sub_in, word, shift_r, add_r;

  function automatic logic [7:0] xt(input logic [7:0] b);
    return {b[6:0], 1'b0} ^ (b[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, x;
    p = 8'h00;
    x = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ x;
      x = xt(x);
    end
    return p;
  endfunction

  function automatic logic [7:0] ginv(input logic [7:0] a);
    logic [7:0] r, q;
    r = 8'h01;
    q = a;
    for (int i = 0; i < 8; i++) begin
      if (i > 0) r = gmul(r, q);
      q = gmul(q, q);
    end
    return r;
  endfunction

  function automatic logic [7:0] rotl(input logic [7:0] b, input int k);
    return (b << k) | (b >> (8 - k));
  endfunction

  function automatic logic [7:0] isbox(input logic [7:0] b);
    return ginv(rotl(b, 1) ^ rotl(b, 3) ^ rotl(b, 6) ^ 8'h05);
  endfunction

  function automatic logic [127:0] isub_all(input logic [127:0] s);
    logic [127:0] o;
    for (int k = 0; k < 16; k++) o[127-8*k -: 8] = isbox(s[127-8*k -: 8]);
    return o;
  endfunction

  function automatic logic [127:0] ishift(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127-8*(4*c+r) -: 8] = s[127-8*(4*((c-r+4)%4)+r) -: 8];
    return o;
  endfunction

  function automatic logic [127:0] imix(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127-32*c -: 8];
      a1 = s[119-32*c -: 8];
      a2 = s[111-32*c -: 8];
      a3 = s[103-32*c -: 8];
      o[127-32*c -: 8] = gmul(a0,8'h0e) ^ gmul(a1,8'h0b) ^ gmul(a2,8'h0d) ^ gmul(a3,8'h09);
      o[119-32*c -: 8] = gmul(a0,8'h09) ^ gmul(a1,8'h0e) ^ gmul(a2,8'h0b) ^ gmul(a3,8'h0d);
      o[111-32*c -: 8] = gmul(a0,8'h0d) ^ gmul(a1,8'h09) ^ gmul(a2,8'h0e) ^ gmul(a3,8'h0b);
      o[103-32*c -: 8] = gmul(a0,8'h0b) ^ gmul(a1,8'h0d) ^ gmul(a2,8'h09) ^ gmul(a3,8'h0e);
    end
    return o;
  endfunction

  assign key_idx = rc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      done      <= 1'b0;
      run       <= 1'b0;
      phase     <= 2'd0;
      rc        <= LAST_RND;
      ct_r      <= '0;
      state     <= '0;
      sub_in    <= '0;
      word      <= '0;
      shift_r   <= '0;
      add_r     <= '0;
      plaintext <= '0;
    end else if (!busy) begin
      if (start) begin
        busy  <= 1'b1;
        done  <= 1'b0;
        run   <= 1'b0;
        rc    <= LAST_RND;
        phase <= 2'd0;
        ct_r  <= ciphertext;
      end
    end else if (!run) begin
      if (key_ready) begin
        state <= ct_r ^ key_data;
        run   <= 1'b1;
        rc    <= LAST_RND - 4'd1;
        phase <= 2'd0;
      end
    end else begin
      case (phase)
        2'd0: begin
          word   <= key_data;
          sub_in <= state;
          phase  <= 2'd1;
        end
        2'd1: begin
          shift_r <= ishift(isub_all(sub_in));
          phase   <= 2'd2;
        end
        2'd2: begin
          if (rc == 4'd0) begin
            plaintext <= shift_r ^ word;
            done      <= 1'b1;
            busy      <= 1'b0;
            run       <= 1'b0;
            phase     <= 2'd0;
          end else begin
            add_r <= imix(shift_r) ^ word;
            phase <= 2'd3;
          end
        end
        default: begin
          state <= add_r;
          rc    <= rc - 4'd1;
          phase <= 2'd0;
        end
      endcase
    end
  end

endmodule

// File: rtl/aes_eic_dec_chk.sv
module aes_eic_dec_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         key_ready,
  input logic         busy,
  input logic         done,
  input logic         run,
  input logic [1:0]   phase,
  input logic [3:0]   key_idx,
  input logic [127:0] plaintext
);

  assert_done_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);

  assert_done_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !start) |=> done);

  assert_pt_change_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(plaintext) |-> $rose(done));

  assert_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !run && !key_ready) |=> (!run && !done));

  assert_wait_idx_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !run) |-> key_idx == 4'd10);

  assert_round_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && phase == 2'd3) |=> (key_idx == $past(key_idx) - 4'd1 && phase == 2'd0));

  assert_busy_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !(run && phase == 2'd2 && key_idx == 4'd0)) |=> busy);

  assert_idx_range_R11: assert property (@(posedge clk) disable iff (!rst_n)
    key_idx <= 4'd10);

endmodule

bind aes_eic_dec aes_eic_dec_chk u_chk (.*);

// File: tb/sim_aes_eic_dec.sv
module sim_aes_eic_dec;
  localparam int CLK_NS = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic         key_ready = 1'b0;
  logic [127:0] ciphertext = '0;
  logic [3:0]   key_idx;
  logic [127:0] key_data;
  logic [127:0] plaintext;
  logic         done, busy;

  logic [127:0] ks [0:10];
  logic [127:0] rk_raw [0:10];
  logic [7:0]   sb [0:255];
  logic [7:0]   isb [0:255];

  int n_chk = 0, n_err = 0;

  always #(CLK_NS/2) clk = ~clk;

  assign key_data = (key_idx <= 4'd10) ? ks[key_idx] : '0;

  aes_eic_dec u0 (.clk(clk), .rst_n(rst_n), .start(start), .key_ready(key_ready),
    .ciphertext(ciphertext), .key_idx(key_idx), .key_data(key_data),
    .plaintext(plaintext), .done(done), .busy(busy));

  task automatic chk(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] bmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] acc = 0, x = a, y = b;
    while (y != 0) begin
      if (y[0]) acc ^= x;
      x = x[7] ? ((x << 1) ^ 8'h1b) : (x << 1);
      y = y >> 1;
    end
    return acc;
  endfunction

  function automatic logic [7:0] getb(input logic [127:0] s, input int r, input int c);
    return s[127 - 8*(4*c + r) -: 8];
  endfunction

  function automatic logic [127:0] t_ishift(input logic [127:0] s);
    logic [127:0] o = s;
    for (int r = 1; r < 4; r++)
      for (int c = 0; c < 4; c++)
        o[127 - 8*(4*((c + r) % 4) + r) -: 8] = getb(s, r, c);
    return o;
  endfunction

  function automatic logic [127:0] t_isub(input logic [127:0] s);
    logic [127:0] o;
    for (int k = 0; k < 16; k++) o[8*k +: 8] = isb[s[8*k +: 8]];
    return o;
  endfunction

  function automatic logic [127:0] t_imix(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] cf [4] = '{8'h0e, 8'h0b, 8'h0d, 8'h09};
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++) begin
        logic [7:0] v = 0;
        for (int j = 0; j < 4; j++) v ^= bmul(cf[(j - r + 4) % 4], getb(s, j, c));
        o[127 - 8*(4*c + r) -: 8] = v;
      end
    return o;
  endfunction

  function automatic logic [127:0] ref_dec(input logic [127:0] ct);
    logic [127:0] s = ct ^ rk_raw[10];
    for (int r = 9; r >= 1; r--) s = t_imix(t_isub(t_ishift(s)) ^ rk_raw[r]);
    return t_isub(t_ishift(s)) ^ rk_raw[0];
  endfunction

  task automatic set_key(input logic [127:0] k);
    logic [31:0] w [44];
    logic [7:0] rcon = 8'h01;
    for (int i = 0; i < 4; i++) w[i] = k[127 - 32*i -: 32];
    for (int i = 4; i < 44; i++) begin
      logic [31:0] t = w[i-1];
      if (i % 4 == 0) begin
        t = {t[23:0], t[31:24]};
        t = {sb[t[31:24]] ^ rcon, sb[t[23:16]], sb[t[15:8]], sb[t[7:0]]};
        rcon = rcon[7] ? ((rcon << 1) ^ 8'h1b) : (rcon << 1);
      end
      w[i] = w[i-4] ^ t;
    end
    for (int r = 0; r <= 10; r++) begin
      rk_raw[r] = {w[4*r], w[4*r+1], w[4*r+2], w[4*r+3]};
      ks[r] = (r == 0 || r == 10) ? rk_raw[r] : t_imix(rk_raw[r]);
    end
  endtask

  // timing reference model
  bit m_busy, m_run, m_done;
  int m_cnt;
  logic [127:0] m_pt, m_exp;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_run = 0; m_done = 0; m_cnt = 0; m_pt = '0;
    end else if (!m_busy) begin
      if (start) begin
        m_busy = 1; m_done = 0; m_run = 0; m_exp = ref_dec(ciphertext);
      end
    end else if (!m_run) begin
      if (key_ready) begin m_run = 1; m_cnt = 1; end
    end else begin
      m_cnt++;
      if (m_cnt == 40) begin m_busy = 0; m_run = 0; m_done = 1; m_pt = m_exp; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk(done == m_done, "R7/R8 done timing", 128'(done), 128'(m_done));
      chk(busy == m_busy, "R7/R9 busy timing", 128'(busy), 128'(m_busy));
      chk(plaintext == m_pt, "R6/R7 plaintext", plaintext, m_pt);
      if (m_busy && !m_run)
        chk(key_idx == 4'd10, "R4 wait index", 128'(key_idx), 128'd10);
      if (m_run)
        chk(int'(key_idx) == 9 - (m_cnt - 1) / 4, "R11 round index", 128'(key_idx), 128'(9 - (m_cnt - 1) / 4));
    end
  end

  task automatic pulse_start(input logic [127:0] ct);
    @(negedge clk);
    ciphertext = ct;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 400; i++) begin
      if (done) break;
      @(negedge clk);
    end
  endtask

  function automatic logic [127:0] rnd128();
    return {$urandom(), $urandom(), $urandom(), $urandom()};
  endfunction

  initial begin
    #(CLK_NS * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [127:0] ct1, exp1;
    for (int x = 0; x < 256; x++) begin
      logic [7:0] inv = 0, s;
      for (int y = 1; y < 256; y++) if (x != 0 && bmul(8'(x), 8'(y)) == 8'h01) inv = 8'(y);
      s = inv ^ {inv[6:0], inv[7]} ^ {inv[5:0], inv[7:6]} ^ {inv[4:0], inv[7:5]} ^ {inv[3:0], inv[7:4]} ^ 8'h63;
      sb[x] = s;
      isb[s] = 8'(x);
    end
    for (int r = 0; r <= 10; r++) ks[r] = '0;

    repeat (3) @(negedge clk);
    chk(!done && !busy && plaintext == '0, "R1 reset state", {plaintext[127:2], busy, done}, '0);
    rst_n = 1'b1;

    // R10 known-answer vector
    set_key(128'h000102030405060708090a0b0c0d0e0f);
    key_ready = 1'b1;
    pulse_start(128'h69c4e0d86a7b0430d8cdb78070b4c55a);
    wait_done();
    chk(plaintext == 128'h00112233445566778899aabbccddeeff, "R10 known answer", plaintext, 128'h00112233445566778899aabbccddeeff);
    repeat (5) @(negedge clk);
    chk(done, "R8 done held", 128'(done), 128'd1);

    // R3 stall, R2 input change after capture
    set_key(rnd128());
    key_ready = 1'b0;
    ct1 = rnd128();
    exp1 = ref_dec(ct1);
    pulse_start(ct1);
    chk(!done, "R8 start clears done", 128'(done), 128'd0);
    ciphertext = ~ct1;
    repeat (25) @(negedge clk);
    chk(!done && busy, "R3 stalled", {busy, done}, 2'b10);
    chk(key_idx == 4'd10, "R4 index while stalled", 128'(key_idx), 128'd10);
    key_ready = 1'b1;
    wait_done();
    chk(plaintext == exp1, "R2 captured ciphertext", plaintext, exp1);

    // R9 start while busy
    ct1 = rnd128();
    exp1 = ref_dec(ct1);
    pulse_start(ct1);
    repeat (15) @(negedge clk);
    pulse_start(rnd128());
    wait_done();
    chk(plaintext == exp1, "R9 busy start ignored", plaintext, exp1);

    // R5 random blocks and keys
    for (int t = 0; t < 4; t++) begin
      @(negedge clk);
      set_key(rnd128());
      ct1 = rnd128();
      exp1 = ref_dec(ct1);
      pulse_start(ct1);
      wait_done();
      chk(plaintext == exp1, "R5 random block", plaintext, exp1);
    end

    repeat (3) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule